// File: doc/BRIEF.md
# Symbol and ADC Clock Divider

This block turns an oscillator clock into two timing strobes: a symbol-rate strobe that marks each rising boundary of the symbol clock, and an ADC strobe that marks each rising edge of the clock fed to an external converter. The oscillator runs at either the symbol rate fs or at twice that rate. Everything runs in the single oscillator clock domain, so both outputs are registered clock-enable pulses rather than derived clocks. A downstream clock buffer or enable-gated logic consumes them.

Configuration arrives on three inputs. A 2-bit rate select gives the oscillator rate. A "converter at symbol rate" bit picks whether the ADC strobe runs at fs or at 2fs. A phase bit picks whether the ADC edge lines up with the symbol edge or sits half a symbol away from it. The block captures all three together, and only on a symbol boundary. A change in mid-symbol therefore never produces a short pulse.

Top module: `clkdiv_sym_adc`

## Requirements
- R1: While `rst` is high at a rising edge, both `sym_en` and `adc_en` are 0 after that edge.
- R2: With the captured rate code 2'b00 (fs oscillator), `sym_en` is 1 in every cycle, with no division.
- R3: With the captured rate code 2'b01 (2fs oscillator), `sym_en` is 1 in every second cycle and 0 in the cycles between.
- R4: With code 2'b01 and `adc_at_sym` = 0, `adc_en` is 1 in every cycle, which is the 2fs rate.
- R5: With code 2'b01, `adc_at_sym` = 1 and `adc_in_phase` = 1, `adc_en` equals `sym_en` in every cycle.
- R6: With code 2'b01, `adc_at_sym` = 1 and `adc_in_phase` = 0, `adc_en` is the inverse of `sym_en` in every cycle, which is 180 degrees of the symbol period.
- R7: With an fs oscillator, `adc_en` is 1 in every cycle. `adc_at_sym` and `adc_in_phase` have no effect on either output.
- R8: The reserved rate codes 2'b10 and 2'b11 behave exactly like 2'b00.
- R9: The block captures the configuration inputs at the clock edge that raises `sym_en`. The outputs of that cycle still follow the previous setting. The new setting governs from the next cycle on.
- R10: After reset, the captured setting is rate code 2'b00, `adc_at_sym` = 1 and `adc_in_phase` = 1. The first cycle after reset therefore has `sym_en` = 1 and `adc_en` = 1, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock, fs or 2fs |
| rst | input | 1 | Synchronous reset, active high |
| osc_rate | input | 2 | Oscillator rate code: 00 fs, 01 2fs, 10/11 treated as 00 |
| adc_at_sym | input | 1 | 1: ADC strobe at fs; 0: ADC strobe at 2fs (2fs oscillator only) |
| adc_in_phase | input | 1 | 1: ADC edge aligned with the symbol edge; 0: 180 degrees away |
| sym_en | output | 1 | Registered strobe, one per symbol-clock rising boundary |
| adc_en | output | 1 | Registered strobe, one per ADC-clock rising edge |

## Verification
Both outputs come from one register stage. A captured setting therefore shows one cycle after the boundary edge that loaded it. A new input first appears two edges after a boundary at the earliest, and as late as three edges after it in 2fs mode. The bench drives inputs and samples outputs on the falling edge. Before each periodic check it waits until a sampled `sym_en` is 1, so every expected pattern is counted from a known symbol boundary. The timing check for R9 changes an input in the cycle just after a boundary. It then expects the old relation for two more samples and the new one on the third sample.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  localparam int RATE_W = 2;

  localparam logic [RATE_W-1:0] RATE_FS  = 2'b00;
  localparam logic [RATE_W-1:0] RATE_2FS = 2'b01;

  typedef struct packed {
    logic dbl;       // oscillator runs at twice the symbol rate
    logic adc_slow;  // ADC strobe held to symbol rate
    logic adc_align; // ADC edge aligned with symbol edge
  } div_cfg_t;

  localparam div_cfg_t CFG_RESET = '{dbl: 1'b0, adc_slow: 1'b1, adc_align: 1'b1};

endpackage

// File: rtl/clkdiv_cfg_latch.sv
module clkdiv_cfg_latch
  import clkdiv_pkg::*;
#(
  parameter int W = RATE_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [W-1:0]   rate_in,
  input  logic           slow_in,
  input  logic           align_in,
  output div_cfg_t       cfg_q
);

  localparam logic [W-1:0] DBL_CODE = W'(RATE_2FS);

  div_cfg_t cfg_d;

  always_comb begin
    cfg_d           = cfg_q;
    if (load) begin
      cfg_d.dbl       = (rate_in == DBL_CODE);
      cfg_d.adc_slow  = slow_in;
      cfg_d.adc_align = align_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= CFG_RESET;
    else     cfg_q <= cfg_d;
  end

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(cfg_q));

endmodule

// File: rtl/clkdiv_phase_gen.sv
module clkdiv_phase_gen
  import clkdiv_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  div_cfg_t cfg,
  output logic     boundary,
  output logic     sym_q,
  output logic     adc_q
);

  logic ph;
  logic ph_d, sym_d, adc_d;

  always_comb begin
    if (cfg.dbl) begin
      ph_d  = ~ph;
      sym_d = ~ph;
      if (!cfg.adc_slow)      adc_d = 1'b1;
      else if (cfg.adc_align) adc_d = ~ph;
      else                    adc_d = ph;
    end else begin
      ph_d  = 1'b1;
      sym_d = 1'b1;
      adc_d = 1'b1;
    end
  end

  assign boundary = sym_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph    <= 1'b1;
      sym_q <= 1'b0;
      adc_q <= 1'b0;
    end else begin
      ph    <= ph_d;
      sym_q <= sym_d;
      adc_q <= adc_d;
    end
  end

  // R3
  no_double_sym_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg.dbl && sym_q) |=> !sym_q);

  // R2
  fs_every_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg.dbl |=> (sym_q && adc_q));

  // R4
  adc_fast_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg.dbl && !cfg.adc_slow) |=> adc_q);

  // R5
  adc_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg.dbl && cfg.adc_slow && cfg.adc_align) |=> (adc_q == sym_q));

  // R6
  adc_opposite_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg.dbl && cfg.adc_slow && !cfg.adc_align) |=> (adc_q != sym_q));

endmodule

// File: rtl/clkdiv_sym_adc.sv
module clkdiv_sym_adc
  import clkdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] osc_rate,
  input  logic              adc_at_sym,
  input  logic              adc_in_phase,
  output logic              sym_en,
  output logic              adc_en
);

  div_cfg_t cfg;
  logic     boundary;

  clkdiv_cfg_latch #(.W(RATE_W)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .load     (boundary),
    .rate_in  (osc_rate),
    .slow_in  (adc_at_sym),
    .align_in (adc_in_phase),
    .cfg_q    (cfg)
  );

  clkdiv_phase_gen u_gen (
    .clk      (clk),
    .rst      (rst),
    .cfg      (cfg),
    .boundary (boundary),
    .sym_q    (sym_en),
    .adc_q    (adc_en)
  );

  // R9
  cfg_on_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg) |-> sym_en);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!sym_en && !adc_en));

endmodule

// File: tb/clkdiv_sym_adc_tb.sv
module clkdiv_sym_adc_tb;

  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] osc_rate = 2'b00;
  logic       adc_at_sym = 1'b1;
  logic       adc_in_phase = 1'b1;
  logic       sym_en, adc_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkdiv_sym_adc u_dut (
    .clk          (clk),
    .rst          (rst),
    .osc_rate     (osc_rate),
    .adc_at_sym   (adc_at_sym),
    .adc_in_phase (adc_in_phase),
    .sym_en       (sym_en),
    .adc_en       (adc_en)
  );

  task automatic expect_pair(string tag, logic es, logic ea);
    n_chk++;
    if (sym_en !== es || adc_en !== ea) begin
      n_bad++;
      $display("FAIL %s: sym_en/adc_en = %b/%b, expected %b/%b at %0t",
               tag, sym_en, adc_en, es, ea, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic find_boundary(string tag);
    for (int k = 0; k < 4; k++) begin
      if (sym_en === 1'b1) return;
      step();
    end
    n_chk++;
    n_bad++;
    $display("FAIL %s: sym_en = %b, expected 1 within 4 cycles", tag, sym_en);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) step();
    expect_pair("R1 reset outputs", 1'b0, 1'b0);
  endtask

  task automatic t_reset_cfg();
    rst = 1'b1;
    osc_rate = 2'b01; adc_at_sym = 1'b0; adc_in_phase = 1'b0;
    step();
    expect_pair("R1 reset held", 1'b0, 1'b0);
    rst = 1'b0;
    step();
    expect_pair("R10 first cycle uses reset setting", 1'b1, 1'b1);
    step();
    expect_pair("R10 R4 captured 2fs fast adc", 1'b0, 1'b1);
    step();
    expect_pair("R3 R4 next boundary", 1'b1, 1'b1);
  endtask

  task automatic t_fs(logic [1:0] code, string tag);
    osc_rate = code;
    repeat (4) step();
    for (int b = 0; b < 4; b++) begin
      adc_at_sym   = b[0];
      adc_in_phase = b[1];
      step();
      expect_pair(tag, 1'b1, 1'b1);
      step();
      expect_pair(tag, 1'b1, 1'b1);
    end
  endtask

  task automatic t_dbl(logic slow, logic align, string tag);
    osc_rate = 2'b01; adc_at_sym = slow; adc_in_phase = align;
    repeat (4) step();
    find_boundary(tag);
    for (int i = 1; i <= 6; i++) begin
      logic es, ea;
      step();
      es = (i % 2 == 0);
      ea = !slow ? 1'b1 : (align ? es : !es);
      expect_pair(tag, es, ea);
    end
  endtask

  task automatic t_mid_change();
    osc_rate = 2'b01; adc_at_sym = 1'b1; adc_in_phase = 1'b1;
    repeat (4) step();
    find_boundary("R9 sync");
    adc_in_phase = 1'b0;
    step();
    expect_pair("R9 old relation mid symbol", 1'b0, 1'b0);
    step();
    expect_pair("R9 old relation at capture edge", 1'b1, 1'b1);
    step();
    expect_pair("R9 new relation after capture", 1'b0, 1'b1);
    step();
    expect_pair("R9 R6 new relation held", 1'b1, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    step();
    t_reset();
    t_reset_cfg();
    t_fs(2'b00, "R2 R7 fs oscillator");
    t_dbl(1'b1, 1'b1, "R3 R5 adc aligned");
    t_dbl(1'b1, 1'b0, "R6 adc opposite");
    t_dbl(1'b0, 1'b0, "R4 adc at 2fs");
    t_fs(2'b10, "R8 code 10 as fs");
    t_dbl(1'b0, 1'b1, "R4 adc at 2fs again");
    t_fs(2'b11, "R8 code 11 as fs");
    t_mid_change();
    t_reset();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run not finished, expected completion");
    finish_run();
  end

endmodule